// File: doc/BRIEF.md
# Host Register Window with Gated Service-Request Launch

This block is the small set of registers that a host reaches directly across a synchronous slave bus on a multichannel controller. It returns the live state of the receive and transmit ports, holds the base address and size of the interrupt queue, and carries an interrupt status word. In that word the host may move the consumer index, and only hardware may move the producer index. A strobe from the hardware advances the producer index.

Work goes to an internal engine through two registers. The host first writes the table address into the request pointer register. It then writes a nonzero entry count into the request length register. The block passes the address and the count to the engine with a one-cycle start pulse. The length stays nonzero until the engine reports completion, and host writes to it are refused while it is nonzero. Just after any reset the length also reads as a fixed nonzero marker for a parameterised number of cycles, so the host cannot launch work before the internal setup finishes. A write to the soft reset location produces a one-cycle pulse that returns every register to its reset value and starts that setup hold again.

Top module: `hostreg_window`

## Requirements
- R1: After reset, the interrupt status word, the queue base and the request pointer read 0, and the request length reads 0 once the setup hold ends. The interrupt queue length register reads 3FFh.
- R2: For INIT_CYCLES clock edges after reset is released (hard or soft), the request length reads INIT_MARK (default FFFFh). Host writes to it in that window are dropped, and a done strobe in that window has no effect.
- R3: A host write to the request length register (offset 14h, entry count in bits [LEN_W-1:0], upper data bits ignored) is taken only while its stored value is zero. While the stored value is nonzero, the write is dropped and the old value stays.
- R4: A taken write with a nonzero count raises eng_start_o for exactly the one cycle after the accepting edge. In that cycle eng_len_o shows the count and eng_ptr_o shows the request pointer (offset 18h).
- R5: A write of a zero count leaves the length at zero and raises no start. An eng_done_i strobe while the length is nonzero clears the length to zero at that edge.
- R6: In the interrupt status word (offset 08h), bits [15:0] are the consumer index and bits [31:16] are the producer index. A host write changes only bits [15:0]. Each cycle with irq_wr_inc_i high adds one to the producer index, which wraps modulo 2^16, and this also applies during a host write.
- R7: Offsets 00h and 04h return rx_alive_i and tx_alive_i, zero-extended. Host writes to them change nothing.
- R8: A write to offset 20h raises soft_rst_o for exactly one cycle. The next edge restores every register to its R1 value and restarts the R2 hold. A read of 20h returns 0.
- R9: The map uses byte offsets 00h rx alive, 04h tx alive, 08h interrupt status, 0Ch queue base, 10h queue length, 14h request length, 18h request pointer and 20h soft reset. Queue base, queue length and request pointer are full read/write words. Any other address, including one that is not dword aligned, reads 0 and ignores writes.
- R10: Read data for a read request appears on rd_data_o after the clock edge that samples the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus access this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Registered read data |
| rx_alive_i | input | NPORT | Receive port alive flags |
| tx_alive_i | input | NPORT | Transmit port alive flags |
| irq_wr_inc_i | input | 1 | Advance interrupt producer index |
| eng_done_i | input | 1 | Engine finished the request |
| eng_start_o | output | 1 | One-cycle request launch |
| eng_len_o | output | LEN_W | Request entry count |
| eng_ptr_o | output | DATA_W | Request table address |
| irq_rd_ptr_o | output | DATA_W/2 | Interrupt consumer index |
| irq_q_base_o | output | DATA_W | Interrupt queue base |
| irq_q_len_o | output | DATA_W | Interrupt queue length |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |

## Verification
The properties assume that the engine raises eng_done_i only while a request is outstanding. They also assume the strobes are single-bit pulses that are synchronous to the clock and never X after reset. The properties on start and length stability also treat a soft reset as the only way to abandon a request. The bench meets these assumptions by driving all inputs on the falling edge. It raises done only after a launch, or on purpose during the setup hold where it must be ignored. It issues the soft reset only through the bus, so every rule about the length register is exercised through the host's own accesses.

// File: rtl/hrw_pkg.sv
package hrw_pkg;

   localparam int unsigned NREG = 8;

   localparam int unsigned IX_RXA = 0;
   localparam int unsigned IX_TXA = 1;
   localparam int unsigned IX_IST = 2;
   localparam int unsigned IX_QBA = 3;
   localparam int unsigned IX_QLN = 4;
   localparam int unsigned IX_SRL = 5;
   localparam int unsigned IX_SRP = 6;
   localparam int unsigned IX_RST = 7;

   // byte offset of each directly mapped register; the soft reset skips 1Ch
   function automatic int unsigned reg_off(input int unsigned idx);
      return (idx == IX_RST) ? 32'd32 : idx * 4;
   endfunction

endpackage

// File: rtl/hrw_decode.sv
module hrw_decode #(
   parameter int unsigned ADDR_W = 6
) (
   input  logic [ADDR_W-1:0]         addr_i,
   output logic [hrw_pkg::NREG-1:0]  sel_o
);

   for (genvar g = 0; g < hrw_pkg::NREG; g++) begin : g_sel
      assign sel_o[g] = (addr_i == ADDR_W'(hrw_pkg::reg_off(g)));
   end

endmodule

// File: rtl/hrw_srq_gate.sv
module hrw_srq_gate #(
   parameter int unsigned        LEN_W       = 16,
   parameter int unsigned        INIT_CYCLES = 8,
   parameter logic [LEN_W-1:0]   INIT_MARK   = '1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             soft_clr_i,
   input  logic             wr_en_i,
   input  logic [LEN_W-1:0] wdata_i,
   input  logic             done_i,
   output logic [LEN_W-1:0] len_view_o,
   output logic [LEN_W-1:0] len_o,
   output logic             start_o,
   output logic             init_busy_o
);

   localparam int unsigned CNT_W = $clog2(INIT_CYCLES + 1);

   logic [CNT_W-1:0] init_cnt;
   logic [LEN_W-1:0] len_q;
   logic             start_q;
   logic             busy_init;
   logic             accept;

   assign busy_init = (init_cnt != '0);
   assign accept    = wr_en_i && !busy_init && (len_q == '0) && (wdata_i != '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         init_cnt <= CNT_W'(INIT_CYCLES);
         len_q    <= '0;
         start_q  <= 1'b0;
      end else if (soft_clr_i) begin
         init_cnt <= CNT_W'(INIT_CYCLES);
         len_q    <= '0;
         start_q  <= 1'b0;
      end else begin
         if (busy_init) begin
            init_cnt <= init_cnt - 1'b1;
         end
         start_q <= accept;
         if (accept) begin
            len_q <= wdata_i;
         end else if (done_i && !busy_init && (len_q != '0)) begin
            len_q <= '0;
         end
      end
   end

   assign len_view_o  = busy_init ? INIT_MARK : len_q;
   assign len_o       = len_q;
   assign start_o     = start_q;
   assign init_busy_o = busy_init;

endmodule

// File: rtl/hrw_irq_status.sv
module hrw_irq_status #(
   parameter int unsigned HALF_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              soft_clr_i,
   input  logic              wr_en_i,
   input  logic [HALF_W-1:0] rd_wdata_i,
   input  logic              inc_i,
   output logic [HALF_W-1:0] rd_ptr_o,
   output logic [HALF_W-1:0] wr_ptr_o
);

   logic [HALF_W-1:0] rd_q;
   logic [HALF_W-1:0] wr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_q <= '0;
         wr_q <= '0;
      end else if (soft_clr_i) begin
         rd_q <= '0;
         wr_q <= '0;
      end else begin
         if (wr_en_i) begin
            rd_q <= rd_wdata_i;
         end
         if (inc_i) begin
            wr_q <= wr_q + 1'b1;
         end
      end
   end

   assign rd_ptr_o = rd_q;
   assign wr_ptr_o = wr_q;

endmodule

// File: rtl/hostreg_window.sv
module hostreg_window #(
   parameter int unsigned      ADDR_W      = 6,
   parameter int unsigned      DATA_W      = 32,
   parameter int unsigned      LEN_W       = 16,
   parameter int unsigned      NPORT       = 16,
   parameter int unsigned      INIT_CYCLES = 8,
   parameter logic [LEN_W-1:0] INIT_MARK   = '1,
   parameter logic [DATA_W-1:0] QLEN_RST   = DATA_W'(32'h3FF),
   parameter bit               REG_RDATA   = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                req_valid_i,
   input  logic                req_write_i,
   input  logic [ADDR_W-1:0]   req_addr_i,
   input  logic [DATA_W-1:0]   req_wdata_i,
   output logic [DATA_W-1:0]   rd_data_o,
   input  logic [NPORT-1:0]    rx_alive_i,
   input  logic [NPORT-1:0]    tx_alive_i,
   input  logic                irq_wr_inc_i,
   input  logic                eng_done_i,
   output logic                eng_start_o,
   output logic [LEN_W-1:0]    eng_len_o,
   output logic [DATA_W-1:0]   eng_ptr_o,
   output logic [DATA_W/2-1:0] irq_rd_ptr_o,
   output logic [DATA_W-1:0]   irq_q_base_o,
   output logic [DATA_W-1:0]   irq_q_len_o,
   output logic                soft_rst_o
);

   import hrw_pkg::*;

   localparam int unsigned HALF_W = DATA_W / 2;

   // elaboration-time parameter checks
   if (ADDR_W < 6) begin : g_chk_addr
      $error("ADDR_W must reach offset 20h");
   end
   if ((DATA_W % 2) != 0 || DATA_W < 16) begin : g_chk_data
      $error("DATA_W must be even and at least 16");
   end
   if (LEN_W < 1 || LEN_W > DATA_W) begin : g_chk_len
      $error("LEN_W must lie in 1..DATA_W");
   end
   if (NPORT < 1 || NPORT > DATA_W) begin : g_chk_port
      $error("NPORT must lie in 1..DATA_W");
   end
   if (INIT_CYCLES < 1) begin : g_chk_init
      $error("INIT_CYCLES must be at least 1");
   end
   if (INIT_MARK == '0) begin : g_chk_mark
      $error("INIT_MARK must be nonzero");
   end

   logic [NREG-1:0]   sel;
   logic [NREG-1:0]   wr_stb;
   logic              rd_req;
   logic              soft_q;
   logic [DATA_W-1:0] qbase_q;
   logic [DATA_W-1:0] qlen_q;
   logic [DATA_W-1:0] srptr_q;
   logic [LEN_W-1:0]  len_view;
   logic [LEN_W-1:0]  srq_len;
   logic              srq_start;
   logic              init_busy;
   logic [HALF_W-1:0] irq_rd_ptr;
   logic [HALF_W-1:0] irq_wr_ptr;
   logic [DATA_W-1:0] rd_mux;

   hrw_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr_i (req_addr_i),
      .sel_o  (sel)
   );

   assign wr_stb = (req_valid_i && req_write_i) ? sel : '0;
   assign rd_req = req_valid_i && !req_write_i;

   hrw_srq_gate #(
      .LEN_W       (LEN_W),
      .INIT_CYCLES (INIT_CYCLES),
      .INIT_MARK   (INIT_MARK)
   ) u_gate (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .soft_clr_i  (soft_q),
      .wr_en_i     (wr_stb[IX_SRL]),
      .wdata_i     (req_wdata_i[LEN_W-1:0]),
      .done_i      (eng_done_i),
      .len_view_o  (len_view),
      .len_o       (srq_len),
      .start_o     (srq_start),
      .init_busy_o (init_busy)
   );

   hrw_irq_status #(.HALF_W(HALF_W)) u_irq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_clr_i (soft_q),
      .wr_en_i    (wr_stb[IX_IST]),
      .rd_wdata_i (req_wdata_i[HALF_W-1:0]),
      .inc_i      (irq_wr_inc_i),
      .rd_ptr_o   (irq_rd_ptr),
      .wr_ptr_o   (irq_wr_ptr)
   );

   // plain read/write words and the soft reset pulse
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         qbase_q <= '0;
         qlen_q  <= QLEN_RST;
         srptr_q <= '0;
         soft_q  <= 1'b0;
      end else if (soft_q) begin
         qbase_q <= '0;
         qlen_q  <= QLEN_RST;
         srptr_q <= '0;
         soft_q  <= 1'b0;
      end else begin
         if (wr_stb[IX_QBA]) qbase_q <= req_wdata_i;
         if (wr_stb[IX_QLN]) qlen_q  <= req_wdata_i;
         if (wr_stb[IX_SRP]) srptr_q <= req_wdata_i;
         soft_q <= wr_stb[IX_RST];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (sel[IX_RXA]) rd_mux[NPORT-1:0] = rx_alive_i;
      if (sel[IX_TXA]) rd_mux[NPORT-1:0] = tx_alive_i;
      if (sel[IX_IST]) rd_mux = {irq_wr_ptr, irq_rd_ptr};
      if (sel[IX_QBA]) rd_mux = qbase_q;
      if (sel[IX_QLN]) rd_mux = qlen_q;
      if (sel[IX_SRL]) rd_mux[LEN_W-1:0] = len_view;
      if (sel[IX_SRP]) rd_mux = srptr_q;
   end

   if (REG_RDATA) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            rdata_q <= '0;
         end else if (rd_req) begin
            rdata_q <= rd_mux;
         end
      end
      assign rd_data_o = rdata_q;
   end else begin : g_rd_comb
      assign rd_data_o = rd_mux;
   end

   assign eng_start_o  = srq_start;
   assign eng_len_o    = srq_len;
   assign eng_ptr_o    = srptr_q;
   assign irq_rd_ptr_o = irq_rd_ptr;
   assign irq_q_base_o = qbase_q;
   assign irq_q_len_o  = qlen_q;
   assign soft_rst_o   = soft_q;

endmodule

// File: rtl/hrw_checker.sv
module hrw_checker #(
   parameter int unsigned LEN_W  = 16,
   parameter int unsigned HALF_W = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              soft_rst,
   input logic              start,
   input logic [LEN_W-1:0]  len,
   input logic              done,
   input logic              init_busy,
   input logic              inc,
   input logic [HALF_W-1:0] wr_ptr
);

   // R4: launch lasts a single cycle
   a_r4_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start |=> !start);

   // R4: a launch always carries a nonzero count
   a_r4_start_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start |-> (len != '0));

   // R3: an outstanding count is held until done or soft reset
   a_r3_len_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((len != '0) && !done && !soft_rst) |=> (len == $past(len)));

   // R5: done clears an outstanding count
   a_r5_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((len != '0) && done && !soft_rst && !init_busy) |=> (len == '0));

   // R2: no launch while the setup hold is active
   a_r2_no_start_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
      init_busy |=> !start);

   // R8: soft reset is one cycle long and restarts the hold
   a_r8_soft_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      soft_rst |=> (!soft_rst && init_busy && (len == '0)));

   // R6: producer index steps by one per strobe
   a_r6_wr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc && !soft_rst) |=> (wr_ptr == HALF_W'($past(wr_ptr) + 1'b1)));

   // R6: producer index is otherwise untouched, host writes included
   a_r6_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc && !soft_rst) |=> $stable(wr_ptr));

endmodule

bind hostreg_window hrw_checker #(
   .LEN_W  (LEN_W),
   .HALF_W (DATA_W/2)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .soft_rst  (soft_rst_o),
   .start     (eng_start_o),
   .len       (eng_len_o),
   .done      (eng_done_i),
   .init_busy (init_busy),
   .inc       (irq_wr_inc_i),
   .wr_ptr    (irq_wr_ptr)
);

// File: tb/hostreg_window_bench.sv
module hostreg_window_bench;

   localparam int unsigned ADDR_W = 6;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned LEN_W  = 16;
   localparam int unsigned NPORT  = 16;
   localparam int unsigned INITC  = 8;
   localparam logic [15:0] MARK   = 16'hFFFF;
   localparam logic [31:0] QRST   = 32'h3FF;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [31:0]       req_wdata = '0;
   logic [31:0]       rd_data;
   logic [15:0]       rx_alive = 16'hA5C3;
   logic [15:0]       tx_alive = 16'h3C5A;
   logic              irq_inc = 1'b0;
   logic              eng_done = 1'b0;
   logic              eng_start;
   logic [15:0]       eng_len;
   logic [31:0]       eng_ptr;
   logic [15:0]       irq_rd_ptr;
   logic [31:0]       irq_q_base;
   logic [31:0]       irq_q_len;
   logic              soft_rst;

   int checks = 0;
   int fails  = 0;

   logic [15:0] m_rd, m_wr, m_len;
   logic [31:0] m_qb, m_ql, m_ptr;
   logic [31:0] d;

   always #10 clk = ~clk;

   hostreg_window u_hostreg_window (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .req_valid_i  (req_valid),
      .req_write_i  (req_write),
      .req_addr_i   (req_addr),
      .req_wdata_i  (req_wdata),
      .rd_data_o    (rd_data),
      .rx_alive_i   (rx_alive),
      .tx_alive_i   (tx_alive),
      .irq_wr_inc_i (irq_inc),
      .eng_done_i   (eng_done),
      .eng_start_o  (eng_start),
      .eng_len_o    (eng_len),
      .eng_ptr_o    (eng_ptr),
      .irq_rd_ptr_o (irq_rd_ptr),
      .irq_q_base_o (irq_q_base),
      .irq_q_len_o  (irq_q_len),
      .soft_rst_o   (soft_rst)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // all bus tasks start and end on a falling edge
   task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] v);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      v = rd_data;
      req_valid = 1'b0;
   endtask

   task automatic done_pulse();
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
   endtask

   function automatic logic [31:0] exp_rd(input int unsigned off);
      case (off)
         0:  return {16'h0, rx_alive};
         4:  return {16'h0, tx_alive};
         8:  return {m_wr, m_rd};
         12: return m_qb;
         16: return m_ql;
         20: return {16'h0, m_len};
         24: return m_ptr;
         default: return 32'h0;
      endcase
   endfunction

   task automatic rd_all(input string tag);
      logic [31:0] v;
      for (int o = 0; o < 64; o += 4) begin
         bus_rd(ADDR_W'(o), v);
         chk($sformatf("%s off %0h", tag, o), v, exp_rd(o));
      end
   endtask

   task automatic model_reset();
      m_rd = '0; m_wr = '0; m_len = '0; m_qb = '0; m_ql = QRST; m_ptr = '0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      logic [31:0] lens [4];
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2: setup hold, one access per cycle; a write lands in the hold
      for (int k = 0; k < 10; k++) begin
         if (k == 4) begin
            bus_wr(6'h14, 32'h7);
            chk("R2 no start in hold", {31'h0, eng_start}, 32'h0);
         end else begin
            bus_rd(6'h14, d);
            chk($sformatf("R2 hold read %0d", k), d, (k < INITC) ? {16'h0, MARK} : 32'h0);
         end
      end
      // R1: reset values
      rd_all("R1 reset");

      // R7: alive words are read only
      bus_wr(6'h00, 32'hFFFF_FFFF);
      bus_wr(6'h04, 32'hFFFF_FFFF);
      rx_alive = 16'h0F0F; tx_alive = 16'h8001;
      bus_rd(6'h00, d); chk("R7 rx alive", d, 32'h0000_0F0F);
      bus_rd(6'h04, d); chk("R7 tx alive", d, 32'h0000_8001);

      // R9 R10: sweep writes over every dword offset except soft reset
      for (int o = 0; o < 64; o += 4) begin
         logic [31:0] v;
         logic        launch;
         if (o == 32) continue;
         v = 32'h9E37_79B9 * (o + 1);
         launch = 1'b0;
         case (o)
            8:  m_rd = v[15:0];
            12: m_qb = v;
            16: m_ql = v;
            20: if (m_len == 0 && v[15:0] != 0) begin m_len = v[15:0]; launch = 1'b1; end
            24: m_ptr = v;
            default: ;
         endcase
         bus_wr(ADDR_W'(o), v);
         if (launch) chk("R4 sweep launch", {31'h0, eng_start}, 32'h1);
         rd_all($sformatf("R9 after wr %0h", o));
      end

      // R9: misaligned accesses
      bus_wr(6'h0D, 32'h1234_5678);
      bus_rd(6'h0C, d); chk("R9 misaligned write ignored", d, m_qb);
      bus_rd(6'h0E, d); chk("R9 misaligned read zero", d, 32'h0);

      // R3: length busy, second write dropped
      bus_wr(6'h14, 32'h55);
      chk("R3 no start when busy", {31'h0, eng_start}, 32'h0);
      bus_rd(6'h14, d); chk("R3 value kept", d, {16'h0, m_len});
      // R5: done clears
      done_pulse();
      m_len = '0;
      bus_rd(6'h14, d); chk("R5 done clears", d, 32'h0);

      // R4 R5: launches with several counts, including truncation and zero
      lens[0] = 32'h1; lens[1] = 32'hFFFF; lens[2] = 32'h0001_2345; lens[3] = 32'h0001_0000;
      for (int i = 0; i < 4; i++) begin
         logic [15:0] cnt;
         m_ptr = 32'h4000_0000 + 32'h100 * i;
         bus_wr(6'h18, m_ptr);
         cnt = lens[i][15:0];
         bus_wr(6'h14, lens[i]);
         if (cnt != 0) begin
            chk("R4 start high", {31'h0, eng_start}, 32'h1);
            chk("R4 eng len", {16'h0, eng_len}, {16'h0, cnt});
            chk("R4 eng ptr", eng_ptr, m_ptr);
            @(negedge clk);
            chk("R4 start one cycle", {31'h0, eng_start}, 32'h0);
            bus_rd(6'h14, d); chk("R4 len reads count", d, {16'h0, cnt});
            done_pulse();
         end else begin
            chk("R5 zero count no start", {31'h0, eng_start}, 32'h0);
         end
         bus_rd(6'h14, d); chk("R5 len idle", d, 32'h0);
      end

      // R6: producer index strobes, host write to consumer only
      irq_inc = 1'b1;
      repeat (5) @(negedge clk);
      irq_inc = 1'b0;
      m_wr = m_wr + 16'd5;
      bus_wr(6'h08, 32'hABCD_0042);
      m_rd = 16'h0042;
      bus_rd(6'h08, d); chk("R6 host touches consumer only", d, {m_wr, m_rd});
      chk("R6 consumer port", {16'h0, irq_rd_ptr}, {16'h0, m_rd});
      irq_inc = 1'b1;
      bus_wr(6'h08, 32'h0000_0777);
      irq_inc = 1'b0;
      m_wr = m_wr + 16'd1; m_rd = 16'h0777;
      bus_rd(6'h08, d); chk("R6 strobe during host write", d, {m_wr, m_rd});
      irq_inc = 1'b1;
      repeat (65536 - int'(m_wr)) @(negedge clk);
      irq_inc = 1'b0;
      m_wr = '0;
      bus_rd(6'h08, d); chk("R6 producer wraps", d, {m_wr, m_rd});

      // R8: soft reset
      bus_rd(6'h20, d); chk("R8 soft reset reads zero", d, 32'h0);
      bus_wr(6'h18, 32'h0000_9000);
      bus_wr(6'h14, 32'h33);
      chk("R8 pre launch", {31'h0, eng_start}, 32'h1);
      bus_wr(6'h20, 32'h1);
      chk("R8 pulse high", {31'h0, soft_rst}, 32'h1);
      @(negedge clk);
      chk("R8 pulse one cycle", {31'h0, soft_rst}, 32'h0);
      chk("R8 len cleared", {16'h0, eng_len}, 32'h0);
      model_reset();
      bus_rd(6'h14, d); chk("R8 hold restarted", d, {16'h0, MARK});
      done_pulse();
      bus_rd(6'h08, d); chk("R8 status cleared", d, 32'h0);
      bus_rd(6'h0C, d); chk("R8 queue base cleared", d, 32'h0);
      bus_rd(6'h10, d); chk("R1 queue length back to 3FF", d, QRST);
      bus_rd(6'h18, d); chk("R8 pointer cleared", d, 32'h0);
      chk("R8 queue len port", irq_q_len, QRST);
      chk("R8 queue base port", irq_q_base, 32'h0);
      repeat (INITC) @(negedge clk);
      bus_rd(6'h14, d); chk("R2 hold ends after soft reset", d, 32'h0);
      bus_wr(6'h14, 32'h9);
      chk("R4 launch after hold", {31'h0, eng_start}, 32'h1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule